// File: doc/BRIEF.md
# Smart-Card Character Receiver (T=0 Error Handling)

This block takes finished characters from a UART-style receive shift register and decides what happens to each one. The shift register delivers 8 data bits and one parity bit. In smart-card mode the block checks even parity. It checks whether the character is a legal initial character while the card's first character is still expected. A good character is copied into a single-entry receive buffer. A bad character is dropped, and the block can answer it by pulling the line low during the guard time, which is the error signal that asks the sender to repeat.

A saturating counter tracks how many bad characters arrived in a row. A status flag rises once that count exceeds a programmable limit. A buffer that is still full when a new good character arrives causes an overrun. The new character is discarded and, if enabled, it is also refused on the line. The buffer-full flag is routed either to an interrupt or to a DMA request. Bit sampling and baud generation are outside this block. `rx_done` is expected in the middle of the parity bit, 9.5 bit times after the start edge.

Top module: `t0_char_rx`

## Requirements
- R1: After reset, `buf_full`, `ovr_flag`, `thr_flag`, `init_active`, `nack_drive`, `rx_irq`, `rx_dma` and `thr_irq` are all 0.
- R2: A character that is accepted while the buffer is empty sets `buf_full`, and its byte appears on `data_out`, on the clock edge that samples `rx_done`.
- R3: With `iso_en`=1, a character whose parity is wrong is not buffered. Parity is correct when the XOR of the 8 data bits and `rx_par` is 0. The character is refused on the line only when `anack_en`=1.
- R4: A refusal drives `nack_drive` high for exactly `BIT_CYC` clock cycles, starting `BIT_CYC` cycles after the edge that sampled `rx_done`. That point is 10.5 bit times after the start edge.
- R5: While `init_active`=1 and `iso_en`=1, a character other than 0x3B or 0x03 is dropped and refused even if `anack_en`=0, and `init_active` stays set. An accepted 0x3B or 0x03 with correct parity is buffered and clears `init_active`. A pulse on `init_start` sets `init_active`.
- R6: Each dropped character increments a consecutive-error count that saturates at its maximum. Every character that is not dropped clears the count. `thr_flag` is set when the count after an increment exceeds `err_thresh`.
- R7: `thr_irq` is high exactly when `thr_flag` and `thr_ie` are both high.
- R8: A character that is not dropped while the buffer is still full and not being read sets `ovr_flag` and leaves `data_out` unchanged. When `iso_en`=1 and `onack_en`=1, it is also refused on the line.
- R9: A pulse on `rd_strobe` clears `buf_full`. A pulse on `clr_thr` clears `thr_flag`, and a pulse on `clr_ovr` clears `ovr_flag`.
- R10: While `buf_full`=1, `rx_dma` is high if `dma_sel`=1. Otherwise `rx_irq` is high if `rxie`=1. The two are never high together.
- R11: With `iso_en`=0, parity is ignored, every character is buffered when there is room, and no refusal is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_en | input | 1 | Smart-card T=0 handling enable |
| anack_en | input | 1 | Refuse characters with bad parity |
| onack_en | input | 1 | Refuse characters that overrun the buffer |
| init_start | input | 1 | Pulse: start expecting an initial character |
| rx_done | input | 1 | Pulse: a character is complete in the shift register |
| rx_data | input | 8 | Data bits of the completed character |
| rx_par | input | 1 | Parity bit of the completed character |
| rd_strobe | input | 1 | Pulse: buffer is being read |
| rxie | input | 1 | Receive interrupt enable |
| dma_sel | input | 1 | Route buffer-full to DMA instead of interrupt |
| thr_ie | input | 1 | Error-threshold interrupt enable |
| err_thresh | input | CNT_W | Consecutive-error limit |
| clr_thr | input | 1 | Pulse: clear the threshold flag |
| clr_ovr | input | 1 | Pulse: clear the overrun flag |
| data_out | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread character |
| ovr_flag | output | 1 | Overrun occurred |
| thr_flag | output | 1 | Consecutive errors exceeded the limit |
| init_active | output | 1 | Initial character still expected |
| nack_drive | output | 1 | 1 = pull the line low (refusal) |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma | output | 1 | Receive DMA request |
| thr_irq | output | 1 | Error-threshold interrupt request |

## Verification
The assertions assume that `rx_done` is a single-cycle pulse. They also assume that characters are spaced at least two bit times apart, so a refusal window never overlaps a new character. The bench keeps to this by waiting out every refusal window before it sends the next character. The bench holds the control enables steady while a character is in flight and changes them only between characters. Strobes such as `rd_strobe`, `clr_thr` and `clr_ovr` are issued only in cycles without `rx_done`, so no assertion has to resolve a same-cycle set and clear.

// File: rtl/t0_char_rx.sv
module t0_char_rx #(
  parameter int          BIT_CYC    = 16,
  parameter int          CNT_W      = 8,
  parameter logic [7:0]  TS_DIRECT  = 8'h3B,
  parameter logic [7:0]  TS_INVERSE = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iso_en,
  input  logic             anack_en,
  input  logic             onack_en,
  input  logic             init_start,
  input  logic             rx_done,
  input  logic [7:0]       rx_data,
  input  logic             rx_par,
  input  logic             rd_strobe,
  input  logic             rxie,
  input  logic             dma_sel,
  input  logic             thr_ie,
  input  logic [CNT_W-1:0] err_thresh,
  input  logic             clr_thr,
  input  logic             clr_ovr,
  output logic [7:0]       data_out,
  output logic             buf_full,
  output logic             ovr_flag,
  output logic             thr_flag,
  output logic             init_active,
  output logic             nack_drive,
  output logic             rx_irq,
  output logic             rx_dma,
  output logic             thr_irq
);
  localparam int         NW      = $clog2(2 * BIT_CYC + 1);
  localparam logic [NW-1:0] WIN  = NW'(2 * BIT_CYC);
  localparam logic [NW-1:0] HALF = NW'(BIT_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             par_err, ts_ok, ts_bad, reject, room, take, overrun, nack_req;
  logic [CNT_W-1:0] err_cnt, err_next;
  logic [NW-1:0]    nack_cnt;

  assign par_err  = ^{rx_par, rx_data};
  assign ts_ok    = (rx_data == TS_DIRECT) || (rx_data == TS_INVERSE);
  assign ts_bad   = init_active && !ts_ok;
  assign reject   = iso_en && (par_err || ts_bad);
  assign room     = !buf_full || rd_strobe;
  assign take     = rx_done && !reject && room;
  assign overrun  = rx_done && !reject && !room;
  assign nack_req = rx_done && iso_en &&
                    ((par_err && anack_en) || ts_bad || (overrun && onack_en));
  assign err_next = (err_cnt == CNT_MAX) ? err_cnt : err_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      buf_full <= 1'b0;
    end else if (take) begin
      data_out <= rx_data;
      buf_full <= 1'b1;
    end else if (rd_strobe) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_flag <= 1'b0;
    else if (overrun)   ovr_flag <= 1'b1;
    else if (clr_ovr)   ovr_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      thr_flag <= 1'b0;
    end else begin
      if (rx_done) err_cnt <= reject ? err_next : '0;
      if (rx_done && reject && (err_next > err_thresh)) thr_flag <= 1'b1;
      else if (clr_thr)                                  thr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   init_active <= 1'b0;
    else if (init_start)          init_active <= 1'b1;
    else if (rx_done && !reject)  init_active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              nack_cnt <= '0;
    else if (nack_req)       nack_cnt <= WIN;
    else if (nack_cnt != '0) nack_cnt <= nack_cnt - 1'b1;
  end

  assign nack_drive = (nack_cnt != '0) && (nack_cnt <= HALF);
  assign rx_dma     = buf_full && dma_sel;
  assign rx_irq     = buf_full && rxie && !dma_sel;
  assign thr_irq    = thr_flag && thr_ie;
endmodule

// File: rtl/t0_char_rx_chk.sv
module t0_char_rx_chk #(
  parameter int         BIT_CYC    = 16,
  parameter logic [7:0] TS_DIRECT  = 8'h3B,
  parameter logic [7:0] TS_INVERSE = 8'h03
) (
  input logic       clk,
  input logic       rst_n,
  input logic       iso_en,
  input logic       init_start,
  input logic       rx_done,
  input logic [7:0] rx_data,
  input logic       rx_par,
  input logic       rd_strobe,
  input logic [7:0] data_out,
  input logic       buf_full,
  input logic       init_active,
  input logic       nack_drive,
  input logic       rx_irq,
  input logic       rx_dma
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= 0;
    else if (nack_drive) run <= run + 1;
    else                 run <= 0;
  end

  assert_take_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !iso_en && !buf_full |=> buf_full && data_out == $past(rx_data));

  assert_bad_parity_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && iso_en && (^{rx_par, rx_data}) && !buf_full |=> !buf_full);

  assert_nack_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nack_drive |-> run < BIT_CYC);

  assert_init_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_active && iso_en && rx_done && !init_start &&
    rx_data != TS_DIRECT && rx_data != TS_INVERSE |=> init_active);

  assert_overrun_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && buf_full && !rd_strobe |=> $stable(data_out) && buf_full);

  assert_read_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !rx_done |=> !buf_full);

  assert_one_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq && rx_dma));
endmodule

bind t0_char_rx t0_char_rx_chk #(.BIT_CYC(BIT_CYC), .TS_DIRECT(TS_DIRECT), .TS_INVERSE(TS_INVERSE)) u_chk (.*);

// File: tb/test_t0_char_rx.sv
module test_t0_char_rx;
  localparam int B = 16;

  logic clk = 0, rst_n = 0;
  logic iso_en = 0, anack_en = 0, onack_en = 0, init_start = 0;
  logic rx_done = 0, rx_par = 0, rd_strobe = 0;
  logic rxie = 0, dma_sel = 0, thr_ie = 0, clr_thr = 0, clr_ovr = 0;
  logic [7:0] rx_data = 0, err_thresh = 8'd2;
  logic [7:0] data_out;
  logic buf_full, ovr_flag, thr_flag, init_active, nack_drive, rx_irq, rx_dma, thr_irq;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  t0_char_rx #(.BIT_CYC(B)) i_t0_char_rx (.*);

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic good_par(input logic [7:0] d);
    return ^d;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    iso_en = 0; anack_en = 0; onack_en = 0; rxie = 0; dma_sel = 0; thr_ie = 0;
    err_thresh = 8'd2;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic send(input logic [7:0] d, input logic p);
    @(negedge clk); rx_data = d; rx_par = p; rx_done = 1;
    @(negedge clk); rx_done = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic watch_nack(output int first, output int len);
    first = -1; len = 0;
    for (int k = 1; k <= 2 * B + 2; k++) begin
      @(negedge clk);
      if (nack_drive) begin
        if (first < 0) first = k;
        len++;
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 buf_full", buf_full, 0);
    check("R1 flags", {ovr_flag, thr_flag, init_active}, 0);
    check("R1 outputs", {nack_drive, rx_irq, rx_dma, thr_irq}, 0);
  endtask

  task automatic t_plain();
    int f, l;
    do_reset();
    send(8'hA5, ~good_par(8'hA5));
    check("R11 buffered despite parity", buf_full, 1);
    check("R11 data", data_out, 8'hA5);
    watch_nack(f, l);
    check("R11 no refusal", l, 0);
    check("R2 data held", data_out, 8'hA5);
    pulse_rd();
    check("R9 read clears full", buf_full, 0);
  endtask

  task automatic t_parity();
    int f, l;
    do_reset();
    iso_en = 1; anack_en = 1;
    send(8'h5C, ~good_par(8'h5C));
    check("R3 not buffered", buf_full, 0);
    watch_nack(f, l);
    check("R4 refusal start", f, B);
    check("R4 refusal length", l, B);
    anack_en = 0;
    send(8'h5C, ~good_par(8'h5C));
    check("R3 not buffered anack off", buf_full, 0);
    watch_nack(f, l);
    check("R3 no refusal anack off", l, 0);
  endtask

  task automatic t_good_route();
    do_reset();
    iso_en = 1; anack_en = 1; rxie = 1;
    send(8'h12, good_par(8'h12));
    check("R2 buffered", buf_full, 1);
    check("R2 data", data_out, 8'h12);
    check("R10 irq", rx_irq, 1);
    check("R10 no dma", rx_dma, 0);
    @(negedge clk); dma_sel = 1; #1;
    check("R10 dma", rx_dma, 1);
    check("R10 irq off under dma", rx_irq, 0);
    pulse_rd();
    check("R10 dma drops after read", rx_dma, 0);
  endtask

  task automatic t_overrun();
    int f, l;
    do_reset();
    iso_en = 1; onack_en = 1;
    send(8'h21, good_par(8'h21));
    send(8'h43, good_par(8'h43));
    check("R8 overrun flag", ovr_flag, 1);
    check("R8 data kept", data_out, 8'h21);
    watch_nack(f, l);
    check("R8 refusal start", f, B);
    check("R8 refusal length", l, B);
    @(negedge clk); clr_ovr = 1; @(negedge clk); clr_ovr = 0;
    check("R9 clr_ovr", ovr_flag, 0);
    check("R9 buffer still full", buf_full, 1);
  endtask

  task automatic t_threshold();
    do_reset();
    iso_en = 1; thr_ie = 1; err_thresh = 8'd2;
    send(8'h01, 1'b0); send(8'h01, 1'b0);
    check("R6 not yet over", thr_flag, 0);
    send(8'h01, 1'b0);
    check("R6 over limit", thr_flag, 1);
    check("R7 thr_irq", thr_irq, 1);
    thr_ie = 0; #1;
    check("R7 masked", thr_irq, 0);
    @(negedge clk); clr_thr = 1; @(negedge clk); clr_thr = 0;
    check("R9 clr_thr", thr_flag, 0);
    send(8'h01, 1'b1);
    pulse_rd();
    send(8'h01, 1'b0); send(8'h01, 1'b0);
    check("R6 good char cleared count", thr_flag, 0);
    err_thresh = 8'd254;
    for (int i = 0; i < 260; i++) send(8'h01, 1'b0);
    check("R6 reaches max", thr_flag, 1);
    @(negedge clk); clr_thr = 1; @(negedge clk); clr_thr = 0;
    send(8'h01, 1'b0);
    check("R6 saturated, no wrap", thr_flag, 1);
  endtask

  task automatic t_init();
    int f, l;
    do_reset();
    iso_en = 1; anack_en = 0;
    @(negedge clk); init_start = 1; @(negedge clk); init_start = 0;
    check("R5 init set", init_active, 1);
    send(8'h55, good_par(8'h55));
    check("R5 bad initial not buffered", buf_full, 0);
    check("R5 still in init", init_active, 1);
    watch_nack(f, l);
    check("R5 refusal length", l, B);
    send(8'h03, good_par(8'h03));
    check("R5 inverse accepted", buf_full, 1);
    check("R5 inverse data", data_out, 8'h03);
    check("R5 init ended", init_active, 0);
    pulse_rd();
    @(negedge clk); init_start = 1; @(negedge clk); init_start = 0;
    send(8'h3B, good_par(8'h3B));
    check("R5 direct accepted", data_out, 8'h3B);
    check("R5 init ended direct", init_active, 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_plain();
    t_parity();
    t_good_route();
    t_overrun();
    t_threshold();
    t_init();
    finish_run();
  end
endmodule